// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block moves a single image frame from a CMOS sensor into an external byte-wide SRAM on request from a host processor. The sensor pixel clock is the block clock. The sensor supplies a frame-valid level, a line-valid level and an 8-bit pixel on every clock. When the host pulses the capture command, the controller arms itself. It then waits until frame-valid rises, so that storing always begins at the top of a fresh frame. From then on, every clock with both frame-valid and line-valid high writes the pixel byte to the next SRAM address, counting from zero.

Once the last pixel of a COLS by ROWS frame has been written, the controller raises a done flag and releases the SRAM. The default frame is 648 by 488. The done flag stays set until the host acknowledges it or commands another capture. The host can therefore start the next capture while it is still working on the stored image.

The SRAM address and data paths are multiplexed. While a capture is armed or running, the sensor side owns the address bus, host read data is forced to zero, and the busy flag is set. At all other times the host address drives the SRAM and the read byte passes through to the host.

Top module: `frame_capture_ctrl`

## Requirements
- R1: After reset, busy, done and memWe are 0.
- R2: While no capture command has been accepted, sensor activity causes no SRAM write (memWe stays 0) and busy stays 0.
- R3: After a capture command, no pixel is stored until frameValid shows a rising edge (low in one clock, high in the next). Pixels of a frame already in progress when the command arrives are not stored.
- R4: During a capture, exactly one write happens per clock in which frameValid and lineValid are both 1. Clocks with lineValid at 0 write nothing. The addresses run from 0 up to COLS*ROWS-1 in steps of one.
- R5: The byte written at each address equals pixData in the clock of that write, and a later host read of that address returns it.
- R6: In the clock after the write to address COLS*ROWS-1, done is 1 and busy is 0. Further sensor pixels are not written.
- R7: done stays 1 until doneAck or capCmd is pulsed. Either pulse clears it in the next clock, and capCmd also starts a new capture (busy 1).
- R8: While busy is 1, hostData reads 0 and memAddr follows the write pointer rather than hostAddr.
- R9: While busy is 0, memAddr equals hostAddr, hostData equals memRData, and memWe is 0.
- R10: A capture command that arrives while busy is 1 is ignored: the write pointer is not reset and the capture completes with COLS*ROWS writes.
- R11: Every accepted capture command resets the write pointer, so the first stored pixel lands at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock, block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| capCmd | input | 1 | One-clock capture request from the host |
| doneAck | input | 1 | One-clock acknowledge of a finished capture |
| frameValid | input | 1 | Sensor frame-valid level |
| lineValid | input | 1 | Sensor line-valid level |
| pixData | input | DW | Sensor pixel byte |
| hostAddr | input | AW | Host read address |
| memRData | input | DW | SRAM read data |
| memAddr | output | AW | SRAM address, multiplexed |
| memWData | output | DW | SRAM write data |
| memWe | output | 1 | SRAM write enable |
| hostData | output | DW | Read data returned to the host, 0 while busy |
| busy | output | 1 | Capture armed or running |
| done | output | 1 | Frame stored, waiting for the host |

## Verification
A write pointer that slips or fails to reset shows up as the wrong first or last write address. It also shows up as a wrong byte at a fixed address when the host reads the buffer back. The address check catches it within one frame, and the readback catches it right after done. A state register stuck in the armed or done state shows within one clock at the busy, done and memWe pins. A missed frame-edge detection appears as writes during the frame that was already running when the command arrived.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic capActive;
  } capStrobe_t;
endpackage

// File: rtl/fcap_ctrl.sv
module fcap_ctrl
  import fcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       capCmd,
  input  logic       doneAck,
  input  logic       frameValid,
  input  logic       lineValid,
  input  logic       lastPix,
  output capStrobe_t stb,
  output logic       busy,
  output logic       done
);
  capState_t st, stNext;
  logic fvPrev;
  logic frameRise;

  assign frameRise = frameValid && !fvPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      fvPrev <= 1'b0;
    end else begin
      st     <= stNext;
      fvPrev <= frameValid;
    end
  end

  always_comb begin
    stb.capActive = (st == ST_ARM) || (st == ST_CAPT);
    stb.incAddr   = (st == ST_CAPT) && frameValid && lineValid;
    stb.clrAddr   = capCmd && ((st == ST_IDLE) || (st == ST_DONE));
  end

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE: if (capCmd) stNext = ST_ARM;
      ST_ARM:  if (frameRise) stNext = ST_CAPT;
      ST_CAPT: if (stb.incAddr && lastPix) stNext = ST_DONE;
      ST_DONE: begin
        if (capCmd)       stNext = ST_ARM;
        else if (doneAck) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign busy = stb.capActive;
  assign done = (st == ST_DONE);

  // R3
  armed_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ARM && !frameRise) |=> (st != ST_CAPT));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CAPT && stb.incAddr && lastPix) |=> (done && !busy));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !capCmd && !doneAck) |=> done);
endmodule

// File: rtl/fcap_datapath.sv
module fcap_datapath
  import fcap_pkg::*;
#(
  parameter int DEPTH = 648 * 488,
  parameter int AW    = 19,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  capStrobe_t    stb,
  input  logic [DW-1:0] pixData,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] memRData,
  output logic          lastPix,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  output logic          memWe,
  output logic [DW-1:0] hostData
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wrAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wrAddr <= '0;
    else if (stb.clrAddr)  wrAddr <= '0;
    else if (stb.incAddr)  wrAddr <= wrAddr + 1'b1;
  end

  assign lastPix  = (wrAddr == LAST);
  assign memWe    = stb.incAddr;
  assign memAddr  = stb.capActive ? wrAddr : hostAddr;
  assign memWData = stb.capActive ? pixData : '0;
  assign hostData = stb.capActive ? '0 : memRData;

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.incAddr && !stb.clrAddr) |=> $stable(wrAddr));

  // R2
  write_in_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr |-> stb.capActive);
endmodule

// File: rtl/frame_capture_ctrl.sv
module frame_capture_ctrl
  import fcap_pkg::*;
#(
  parameter int COLS = 648,
  parameter int ROWS = 488,
  parameter int DW   = 8,
  localparam int DEPTH = COLS * ROWS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          capCmd,
  input  logic          doneAck,
  input  logic          frameValid,
  input  logic          lineValid,
  input  logic [DW-1:0] pixData,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] memRData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  output logic          memWe,
  output logic [DW-1:0] hostData,
  output logic          busy,
  output logic          done
);
  capStrobe_t stb;
  logic lastPix;

  fcap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .capCmd(capCmd), .doneAck(doneAck),
    .frameValid(frameValid), .lineValid(lineValid), .lastPix(lastPix),
    .stb(stb), .busy(busy), .done(done)
  );

  fcap_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .pixData(pixData),
    .hostAddr(hostAddr), .memRData(memRData), .lastPix(lastPix),
    .memAddr(memAddr), .memWData(memWData), .memWe(memWe),
    .hostData(hostData)
  );
endmodule

// File: tb/tb_frame_capture_ctrl.sv
module tb_frame_capture_ctrl;
  localparam int CLK_P = 10;
  localparam int COLS  = 6;
  localparam int ROWS  = 4;
  localparam int DEPTH = COLS * ROWS;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capCmd = 1'b0, doneAck = 1'b0, frameValid = 1'b0, lineValid = 1'b0;
  logic [7:0] pixData = '0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0] memRData;
  logic [AW-1:0] memAddr;
  logic [7:0] memWData, hostData;
  logic memWe, busy, done;

  logic [7:0] mem [0:DEPTH-1];

  int nTests = 0, nFail = 0;
  int weCount, firstAddr, lastAddr;

  always #(CLK_P/2) clk = ~clk;

  frame_capture_ctrl #(.COLS(COLS), .ROWS(ROWS)) dut (
    .clk(clk), .rstN(rstN), .capCmd(capCmd), .doneAck(doneAck),
    .frameValid(frameValid), .lineValid(lineValid), .pixData(pixData),
    .hostAddr(hostAddr), .memRData(memRData), .memAddr(memAddr),
    .memWData(memWData), .memWe(memWe), .hostData(hostData),
    .busy(busy), .done(done)
  );

  always @(posedge clk) if (memWe) mem[memAddr] <= memWData;
  assign memRData = mem[memAddr];

  // readback vectors for base pattern 0: value = addr*7+3
  typedef struct packed { logic [7:0] addr; logic [7:0] val; } rdVec_t;
  localparam rdVec_t RD_TAB [8] = '{
    '{8'd0, 8'd3},   '{8'd1, 8'd10},  '{8'd5, 8'd38},  '{8'd6, 8'd45},
    '{8'd11, 8'd80}, '{8'd12, 8'd87}, '{8'd17, 8'd122}, '{8'd23, 8'd164}
  };

  function automatic logic [7:0] pat(int base, int k);
    return 8'((k * 7 + 3 + base) % 256);
  endfunction

  task automatic chk(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic fv, logic lv, logic [7:0] d, logic cmd);
    @(negedge clk);
    frameValid = fv; lineValid = lv; pixData = d; capCmd = cmd;
    #1;
    if (memWe) begin
      weCount++;
      if (firstAddr < 0) firstAddr = int'(memAddr);
      lastAddr = int'(memAddr);
    end
  endtask

  task automatic sendFrame(int base, int cmdAt);
    int k = 0;
    weCount = 0; firstAddr = -1; lastAddr = -1;
    drive(1'b0, 1'b0, 8'h00, 1'b0);
    drive(1'b0, 1'b0, 8'h00, 1'b0);
    drive(1'b1, 1'b0, 8'h00, 1'b0);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        drive(1'b1, 1'b1, pat(base, k), (k == cmdAt));
        k++;
      end
      drive(1'b1, 1'b0, 8'h00, 1'b0);
      drive(1'b1, 1'b0, 8'h00, 1'b0);
    end
    drive(1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic readAt(string req, int a, int exp);
    @(negedge clk);
    hostAddr = AW'(a);
    #1;
    chk(req, int'(hostData), exp);
    chk(req, int'(memAddr), a);
  endtask

  initial begin
    #(CLK_P * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hEE;
    #(CLK_P * 3);
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 memWe", int'(memWe), 0);
    rstN = 1'b1;

    // R2 frame without command
    sendFrame(0, -1);
    chk("R2 writes", weCount, 0);
    chk("R2 busy", int'(busy), 0);
    readAt("R2 untouched", 0, 8'hEE);

    // R3 command during a running frame
    weCount = 0; firstAddr = -1;
    drive(1'b1, 1'b0, 8'h00, 1'b0);
    drive(1'b1, 1'b0, 8'h00, 1'b1);
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, 8'h55, 1'b0);
    chk("R3 busy", int'(busy), 1);
    chk("R3 no write mid frame", weCount, 0);
    chk("R8 hostData", int'(hostData), 0);

    // R4 R5 R6 R11 full capture
    sendFrame(0, -1);
    chk("R4 write count", weCount, DEPTH);
    chk("R11 first addr", firstAddr, 0);
    chk("R4 last addr", lastAddr, DEPTH - 1);
    chk("R6 done", int'(done), 1);
    chk("R6 busy", int'(busy), 0);
    weCount = 0;
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 8'h77, 1'b0);
    drive(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R6 no write after done", weCount, 0);

    // R5 R9 readback table
    for (int i = 0; i < 8; i++) readAt("R5 R9 readback", int'(RD_TAB[i].addr), int'(RD_TAB[i].val));

    // R7 hold, then ack
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R7 done held", int'(done), 1);
    @(negedge clk); doneAck = 1'b1;
    @(negedge clk); doneAck = 1'b0;
    #1;
    chk("R7 ack clears", int'(done), 0);

    // R8 R11 new capture
    @(negedge clk); hostAddr = AW'(3); capCmd = 1'b1;
    @(negedge clk); capCmd = 1'b0;
    #1;
    chk("R8 busy", int'(busy), 1);
    chk("R8 memAddr", int'(memAddr), 0);
    chk("R8 hostData", int'(hostData), 0);

    // R10 command mid capture ignored
    sendFrame(100, 10);
    chk("R10 write count", weCount, DEPTH);
    chk("R10 last addr", lastAddr, DEPTH - 1);
    chk("R10 done", int'(done), 1);
    readAt("R10 readback", 23, int'(pat(100, 23)));
    readAt("R10 readback", 10, int'(pat(100, 10)));

    // R7 command from done restarts
    @(negedge clk); capCmd = 1'b1;
    @(negedge clk); capCmd = 1'b0;
    #1;
    chk("R7 cmd clears done", int'(done), 0);
    chk("R7 cmd sets busy", int'(busy), 1);
    sendFrame(50, -1);
    chk("R11 first addr", firstAddr, 0);
    readAt("R11 readback", 0, int'(pat(50, 0)));
    chk("R9 memWe idle", int'(memWe), 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule